// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block times the marks and spaces of a demodulated infrared envelope. The envelope is synchronised and passed through a glitch filter. Selected edges of the filtered level start and stop a width timer. The timer advances once per tick of a programmable receive divider. Each finished interval is written to a small receive FIFO as one entry. An entry holds the upper bits of the timer and the level that was held during the interval. Software reads the entries through a register port, and an interrupt output flags timeouts, overruns and a FIFO service request.

If the timer overflows, the block stops timing and raises a sticky timeout flag. It also writes an all-ones marker entry, unless the control register suppresses that entry. If an entry arrives while the FIFO is full, the entry is lost and a sticky overrun flag is set. Neither flag is cleared by a register write. The timeout flag clears only while the receiver is disabled, and the overrun flag clears only while the FIFO is disabled. A driver therefore toggles the relevant enable to acknowledge each condition.

Register map (addr_i): 0 control, 1 divider, 2 filter count, 3 status (read only), 4 interrupt enables, 5 FIFO (read pops). Control bits: 0 receiver enable, 1 FIFO enable, 3:2 edge select, 4 watermark select, 5 suppress overflow entry. Status bits: 0 timeout, 1 overrun, 2 busy, 3 service request.

Top module: `ir_pw_rx`

## Requirements
- R1: With divider value D, the width timer advances once every D+1 clock cycles. For filtered edges W cycles apart, the timer holds floor((W-1)/(D+1)) when it closes the interval. The entry stores timer bits [TMR_W-1:2] in entry bits [TMR_W-3:0] (bits 15:0 by default).
- R2: Entry bit TMR_W-2 (bit 16 by default) holds the filtered level that was present during the measured interval.
- R3: A FIFO read of a non-empty FIFO returns the entry with bit TMR_W-1 (bit 17 by default) set, and pops that entry. A read of an empty FIFO returns 0.
- R4: Edge select 0 never starts the timer. Edge select 1 uses falling edges only, 2 uses rising edges only, and 3 uses both. Each selected edge closes the running interval and starts the next one.
- R5: With filter count N>0, a level change that lasts fewer than N cycles is ignored, and a change that lasts N or more cycles passes. With N=0 the filter is bypassed.
- R6: When the timer would advance past all ones, it stops. An entry with every data and level bit set is written (0x1FFFF by default), and the timeout status bit is set.
- R7: With control bit 5 set, a timer overflow sets the timeout status bit but writes no entry.
- R8: The timeout status bit stays set until the receiver enable is cleared. Toggling the FIFO enable does not clear it.
- R9: The FIFO holds DEPTH (default 8) entries. An entry that arrives while the FIFO is full is dropped and sets the overrun status bit. That bit is cleared only while the FIFO enable is 0, and clearing the FIFO enable also empties the FIFO.
- R10: The service request status bit is set when the FIFO holds at least DEPTH/2 entries (control bit 4 = 0), or when it holds at least one entry (control bit 4 = 1).
- R11: irq_o is the OR of timeout with enable bit 0, overrun with enable bit 1, and service request with enable bit 4.
- R12: The busy status bit is 1 exactly while the timer is running. Clearing the receiver enable stops the timer.
- R13: After reset, the control, divider, filter and enable registers read 0, the status reads 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (pops the FIFO at address 5) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| env_i | input | 1 | Demodulated IR envelope, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full FIFO that receives a ninth entry while the service request is already pending. That state has to be combined with exact interval widths, because each status probe costs register-port cycles while the envelope keeps running. The bench drives fixed 8-cycle intervals and places every status read inside an interval of the same length, so every entry's count stays predictable up to and beyond the overrun. Timer overflow is reached by building the bench with a 10-bit timer, which lets the timeout and marker paths run within the cycle budget.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_FALL = 2'd1,
    EDG_RISE = 2'd2,
    EDG_ANY  = 2'd3
  } edge_sel_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd1;
  localparam logic [2:0] A_FILT = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_FIFO = 3'd5;

  typedef struct packed {
    logic      no_ovf_load;
    logic      wm_any;
    edge_sel_e edge_sel;
    logic      fifo_en;
    logic      rx_en;
  } ctrl_t;
endpackage

// File: rtl/ir_rx_glitch_filter.sv
module ir_rx_glitch_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             lvl_o
);
  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             raw;
  logic             pass;

  assign raw  = sync_q[1];
  // level change accepted on its min_i-th consecutive sample
  assign pass = ({1'b0, cnt_q} + 1'b1) >= {1'b0, min_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lvl_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (raw == lvl_o) begin
        cnt_q <= '0;
      end else if (pass) begin
        lvl_o <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_rx_width_timer.sv
module ir_rx_width_timer #(
  parameter int TMR_W = 18,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic             lvl_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             no_load_i,
  output logic             push_o,
  output logic [TMR_W-2:0] push_data_o,
  output logic             ovf_o,
  output logic             busy_o
);
  logic             lvl_q, run_q;
  logic [TMR_W-1:0] tmr_q;
  logic [DIV_W-1:0] pc_q;
  logic             rise, fall, hit, tick;

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;
  assign hit  = en_i & ((sel_i[0] & fall) | (sel_i[1] & rise));
  assign tick = run_q & (pc_q == '0);

  assign ovf_o       = en_i & ~hit & tick & (&tmr_q);
  assign push_o      = (hit & run_q) | (ovf_o & ~no_load_i);
  assign push_data_o = ovf_o ? '1 : {lvl_q, tmr_q[TMR_W-1:2]};
  assign busy_o      = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= 1'b0;
      tmr_q <= '0;
      pc_q  <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (!en_i) begin
        run_q <= 1'b0;
        tmr_q <= '0;
        pc_q  <= div_i;
      end else if (hit) begin
        run_q <= 1'b1;
        tmr_q <= '0;
        pc_q  <= div_i;
      end else if (tick) begin
        pc_q <= div_i;
        if (&tmr_q) run_q <= 1'b0;
        else        tmr_q <= tmr_q + 1'b1;
      end else if (run_q) begin
        pc_q <= pc_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          wr_ok, rd_ok;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign wr_ok   = push_i & ~full_o;
  assign rd_ok   = pop_i & ~empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/ir_pw_rx.sv
module ir_pw_rx
  import ir_rx_pkg::*;
#(
  parameter int TMR_W  = 18,
  parameter int DIV_W  = 16,
  parameter int FILT_W = 16,
  parameter int DEPTH  = 8,
  localparam int ENT_W = TMR_W - 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        env_i,
  output logic        irq_o
);
  ctrl_t              ctrl_q;
  logic [DIV_W-1:0]   div_q;
  logic [FILT_W-1:0]  filt_q;
  logic [4:0]         ien_q;
  logic               to_q, ovr_q;

  logic               lvl;
  logic               tmr_push, tmr_ovf, busy;
  logic [ENT_W-1:0]   tmr_data, head;
  logic [CW-1:0]      fifo_cnt;
  logic               full, empty, pop, sreq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      filt_q <= '0;
      ien_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: ctrl_q <= ctrl_t'(wdata_i[5:0]);
        A_DIV:  div_q  <= wdata_i[DIV_W-1:0];
        A_FILT: filt_q <= wdata_i[FILT_W-1:0];
        A_IEN:  ien_q  <= wdata_i[4:0];
        default: ;
      endcase
    end
  end

  ir_rx_glitch_filter #(.CNT_W(FILT_W)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (env_i),
    .min_i (filt_q),
    .lvl_o (lvl)
  );

  ir_rx_width_timer #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.rx_en),
    .sel_i      (ctrl_q.edge_sel),
    .lvl_i      (lvl),
    .div_i      (div_q),
    .no_load_i  (ctrl_q.no_ovf_load),
    .push_o     (tmr_push),
    .push_data_o(tmr_data),
    .ovf_o      (tmr_ovf),
    .busy_o     (busy)
  );

  assign pop = re_i & (addr_i == A_FIFO);

  ir_rx_fifo #(.DW(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(~ctrl_q.fifo_en),
    .push_i (tmr_push & ctrl_q.fifo_en),
    .data_i (tmr_data),
    .pop_i  (pop),
    .head_o (head),
    .count_o(fifo_cnt),
    .full_o (full),
    .empty_o(empty)
  );

  // sticky flags, cleared only through the enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (!ctrl_q.rx_en) to_q <= 1'b0;
      else if (tmr_ovf)  to_q <= 1'b1;
      if (!ctrl_q.fifo_en)      ovr_q <= 1'b0;
      else if (tmr_push & full) ovr_q <= 1'b1;
    end
  end

  assign sreq  = ctrl_q.wm_any ? ~empty : (fifo_cnt >= CW'(DEPTH / 2));
  assign irq_o = (to_q & ien_q[0]) | (ovr_q & ien_q[1]) | (sreq & ien_q[4]);

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = 32'(ctrl_q);
      A_DIV:   rdata_o = 32'(div_q);
      A_FILT:  rdata_o = 32'(filt_q);
      A_STAT:  rdata_o = 32'({sreq, busy, ovr_q, to_q});
      A_IEN:   rdata_o = 32'(ien_q);
      A_FIFO:  rdata_o = empty ? 32'd0 : 32'({1'b1, head});
      default: rdata_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/ir_pw_rx_chk.sv
module ir_pw_rx_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en,
  input logic          fifo_en,
  input logic [1:0]    edge_sel,
  input logic          to_q,
  input logic          ovr_q,
  input logic          busy,
  input logic [CW-1:0] fifo_cnt,
  input logic          re_i,
  input logic [2:0]    addr_i,
  input logic [31:0]   rdata_o
);
  AST_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && rx_en) |=> to_q); // R8
  AST_TO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !to_q); // R8
  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && fifo_en) |=> ovr_q); // R9
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH)); // R9
  AST_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel == 2'd0 && !busy) |=> !busy); // R4
  AST_BUSY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> !busy); // R12
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 3'd5 && fifo_cnt == '0) |-> rdata_o == 32'd0); // R3
endmodule

bind ir_pw_rx ir_pw_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rx_en   (ctrl_q.rx_en),
  .fifo_en (ctrl_q.fifo_en),
  .edge_sel(ctrl_q.edge_sel),
  .to_q    (to_q),
  .ovr_q   (ovr_q),
  .busy    (busy),
  .fifo_cnt(fifo_cnt),
  .re_i    (re_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o)
);

// File: tb/sim_ir_pw_rx.sv
module sim_ir_pw_rx;
  localparam int TW = 10;
  localparam logic [31:0] LVL = 32'h100;
  localparam logic [31:0] NDV = 32'h200;
  localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_FILT = 3'd2,
                         A_STAT = 3'd3, A_IEN = 3'd4, A_FIFO = 3'd5;
  localparam logic [15:0] RX = 16'h1, FE = 16'h2, E_FALL = 16'h4, E_RISE = 16'h8,
                          E_BOTH = 16'hC, WM = 16'h10, NOLD = 16'h20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, env = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ir_pw_rx #(.TMR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .env_i(env), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); re = 1'b1; addr = a;
    #2 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic hold(input logic l, input int n);
    env = l;
    repeat (n) @(negedge clk);
  endtask

  task automatic step();
    env = ~env;
    repeat (8) @(negedge clk);
  endtask

  task automatic step_stat(input string req, input logic [31:0] exp);
    env = ~env;
    repeat (6) @(negedge clk);
    rd_chk(req, A_STAT, exp);
  endtask

  task automatic cfg(input logic [15:0] c);
    wr(A_CTRL, 16'h0);
    wr(A_CTRL, c);
  endtask

  task automatic t_reset();
    rd_chk("R13 ctrl", A_CTRL, 0);
    rd_chk("R13 div", A_DIV, 0);
    rd_chk("R13 filt", A_FILT, 0);
    rd_chk("R13 ien", A_IEN, 0);
    rd_chk("R13 stat", A_STAT, 0);
    rd_chk("R3 empty fifo", A_FIFO, 0);
    check("R13 irq", 32'(irq), 0);
  endtask

  task automatic t_both();
    cfg(RX | FE | E_BOTH | WM);
    hold(1, 21); hold(0, 13); hold(1, 5); hold(0, 8);
    rd_chk("R12 busy with wm-any sreq", A_STAT, 32'hC);
    rd_chk("R1 R2 first mark", A_FIFO, NDV | LVL | 5);
    rd_chk("R1 R2 space", A_FIFO, NDV | 3);
    rd_chk("R1 R3 short mark", A_FIFO, NDV | LVL | 1);
    rd_chk("R3 read after drain", A_FIFO, 0);
    wr(A_CTRL, 0);
    rd_chk("R12 busy off", A_STAT, 0);
  endtask

  task automatic t_div();
    wr(A_DIV, 16'd2);
    cfg(RX | FE | E_BOTH | WM);
    hold(1, 40); hold(0, 64); hold(1, 8);
    rd_chk("R1 div mark", A_FIFO, NDV | LVL | 3);
    rd_chk("R1 div space", A_FIFO, NDV | 5);
    wr(A_CTRL, 0); wr(A_DIV, 0);
    hold(0, 4);
  endtask

  task automatic t_edges();
    cfg(RX | FE | WM);
    hold(1, 10); hold(0, 10);
    rd_chk("R4 edge off status", A_STAT, 0);
    rd_chk("R4 edge off fifo", A_FIFO, 0);
    cfg(RX | FE | E_RISE | WM);
    hold(1, 10); hold(0, 15); hold(1, 8);
    rd_chk("R4 rise only period", A_FIFO, NDV | 6);
    rd_chk("R4 rise only single", A_FIFO, 0);
    cfg(RX | FE | E_FALL | WM);
    hold(0, 8); hold(1, 12); hold(0, 8);
    rd_chk("R4 fall only period", A_FIFO, NDV | LVL | 4);
    rd_chk("R4 fall only single", A_FIFO, 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_filter();
    wr(A_FILT, 16'd6);
    cfg(RX | FE | E_BOTH | WM);
    hold(1, 5); hold(0, 10); hold(1, 8); hold(0, 3); hold(1, 12);
    hold(0, 12); hold(1, 6); hold(0, 15); hold(1, 16);
    rd_chk("R5 glitches merged", A_FIFO, NDV | LVL | 5);
    rd_chk("R5 space", A_FIFO, NDV | 2);
    rd_chk("R5 boundary pulse passes", A_FIFO, NDV | LVL | 1);
    rd_chk("R5 last space", A_FIFO, NDV | 3);
    rd_chk("R5 short glitch rejected", A_FIFO, 0);
    wr(A_CTRL, 0); wr(A_FILT, 0);
    hold(0, 4);
  endtask

  task automatic t_ovf();
    cfg(RX | FE | E_BOTH | WM);
    wr(A_IEN, 16'h1);
    hold(1, 1100);
    rd_chk("R6 timeout status", A_STAT, 32'h9);
    check("R11 timeout irq", 32'(irq), 1);
    rd_chk("R6 marker entry", A_FIFO, 32'h3FF);
    rd_chk("R6 single marker", A_FIFO, 0);
    wr(A_CTRL, RX | E_BOTH | WM); wr(A_CTRL, RX | FE | E_BOTH | WM);
    rd_chk("R8 fifo toggle keeps timeout", A_STAT, 32'h1);
    wr(A_CTRL, FE | E_BOTH | WM); wr(A_CTRL, RX | FE | E_BOTH | WM);
    rd_chk("R8 rx toggle clears timeout", A_STAT, 0);
    check("R11 irq after clear", 32'(irq), 0);
    cfg(RX | FE | E_BOTH | WM | NOLD);
    hold(0, 1100);
    rd_chk("R7 timeout without entry", A_STAT, 32'h1);
    rd_chk("R7 no marker", A_FIFO, 0);
    wr(A_IEN, 16'h0);
    check("R11 masked", 32'(irq), 0);
    wr(A_CTRL, 0);
    hold(0, 4);
  endtask

  task automatic t_fifo();
    cfg(RX | FE | E_BOTH);
    step(); step(); step();
    step_stat("R10 three entries below half", 32'h4);
    step_stat("R10 four entries at half", 32'hC);
    step(); step(); step();
    step_stat("R9 full no overrun", 32'hC);
    step_stat("R9 ninth entry overruns", 32'hE);
    wr(A_IEN, 16'h10);
    check("R11 sreq irq", 32'(irq), 1);
    wr(A_IEN, 16'h2);
    check("R11 overrun irq", 32'(irq), 1);
    for (int i = 0; i < 8; i++)
      rd_chk("R9 kept entry", A_FIFO, NDV | ((i % 2 == 0) ? LVL : 0) | 1);
    rd_chk("R9 dropped entry absent", A_FIFO, 0);
    wr(A_CTRL, FE | E_BOTH); wr(A_CTRL, RX | FE | E_BOTH);
    rd_chk("R9 rx toggle keeps overrun", A_STAT, 32'h2);
    wr(A_CTRL, RX | E_BOTH); wr(A_CTRL, RX | FE | E_BOTH);
    rd_chk("R9 fifo toggle clears overrun", A_STAT, 0);
    wr(A_IEN, 16'h0);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_both();
    t_div();
    t_edges();
    t_filter();
    t_ovf();
    t_fifo();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule